// File: doc/BRIEF.md
# Hot-plug slot presence and reset sequencer

This block supervises a group of hot-plug slots. For every slot it takes a raw card-presence input, a power-good input from the slot's power switch and an enable from software. The presence input is filtered on a slow sample tick, so that contact bounce cannot toggle the slot. Power is granted to a slot only while a card is present and software allows it. The slot's active-low reset is held until power-good has stayed high for a programmed number of ticks. If several slots become ready in the same cycle, their resets are released one slot per clock cycle, lowest slot number first.

Each filtered insert or removal, each power-good edge and each reset change is written into a small event queue. Every entry carries a timestamp taken from a free-running tick counter. Management software drains the queue in the order the events happened. This lets it tell a bouncing connector apart from a link that keeps dropping. A single slot can be power-cycled through its enable bit without any effect on the other slots.

Top module: `hp_slot_seq`

## Requirements
- R1: A slot's `present` bit changes only on a `tick` cycle, and only after `deb_len` consecutive ticks on which `prs_raw` differed from `present`. A tick with equal values restarts the count. A `deb_len` of 0 behaves as 1.
- R2: `slot_pwr_en[i]` is high exactly when `present[i]` and `sw_en[i]` are high and the slot has no latched power fault. Each slot is independent of the others.
- R3: If `pgood[i]` falls in a cycle where `slot_pwr_en[i]` is high, a power fault is latched for that slot. The latch turns the slot's power off from the next cycle and holds it off until `sw_en[i]` is seen low.
- R4: `slot_rst_n[i]` rises only after power is on and `pgood[i]` has stayed high for `rel_dly` ticks. Any cycle with power or power-good low restarts that count from zero.
- R5: At most one slot's reset is released per clock cycle. Among slots that are ready together, the lowest index is released first.
- R6: `slot_rst_n[i]` goes low in the same cycle that `pgood[i]` or `slot_pwr_en[i]` goes low. The other slots are not affected.
- R7: Each queue entry holds the slot index (`ev_slot`), a 3-bit code (`ev_code`) and `ev_ts`. The codes are: 0 insert, 1 removal, 2 power-good rise, 3 power-good fall, 4 reset release, 5 reset assert. `ev_ts` is the number of ticks seen since reset, modulo 2^TS_W, in the cycle where the event occurs.
- R8: Events from the same cycle are queued in ascending slot order. Within one slot the order is presence, then power-good, then reset.
- R9: When the queue has no room, the newest events of that cycle are dropped and `ev_ovf` is set. `ev_ovf` stays set until reset. The queue counts an entry freed by a read in that same cycle as still occupied.
- R10: `ev_valid` is high while the queue holds entries, and the outputs show the oldest entry. `ev_rd` with `ev_valid` high removes that entry at the clock edge.
- R11: After reset all outputs are low, the queue is empty and the tick count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the sample and timestamp rate |
| prs_raw | input | NSLOT | Unfiltered presence per slot, high means a card is present |
| pgood | input | NSLOT | Slot power-good |
| sw_en | input | NSLOT | Software power enable per slot |
| deb_len | input | DEB_W | Stable ticks needed before presence changes |
| rel_dly | input | DLY_W | Ticks of good power before reset release |
| present | output | NSLOT | Filtered presence |
| slot_pwr_en | output | NSLOT | Slot power switch enable |
| slot_rst_n | output | NSLOT | Active-low slot reset |
| ev_rd | input | 1 | Read strobe, removes the head entry |
| ev_valid | output | 1 | Queue holds an entry |
| ev_slot | output | SLOT_W | Slot index of the head entry |
| ev_code | output | 3 | Event code of the head entry |
| ev_ts | output | TS_W | Timestamp of the head entry |
| ev_ovf | output | 1 | Sticky flag set when events were dropped |

## Verification
The case that matters most is a group of slots whose power-good inputs all rise in one cycle. That cycle writes several events together, and the reset releases then spread over the following cycles. The bench forces this with all four slots while it holds `ev_rd` low, so the multi-entry write lands on a queue that is filling up. A bench-side queue model decides which entries survive and in what order. A second collision comes from random stimulus: a read and a multi-event write fall in the same cycle, and one slot loses power-good while another slot's reset is being released. Queue contents and reset levels are compared with the model in every cycle.

// File: rtl/hp_slot_seq.sv
module hp_slot_seq #(
  parameter int NSLOT = 4,
  parameter int DEB_W = 8,
  parameter int DLY_W = 8,
  parameter int TS_W = 16,
  parameter int EV_DEPTH = 8,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NSLOT-1:0]  prs_raw,
  input  logic [NSLOT-1:0]  pgood,
  input  logic [NSLOT-1:0]  sw_en,
  input  logic [DEB_W-1:0]  deb_len,
  input  logic [DLY_W-1:0]  rel_dly,
  output logic [NSLOT-1:0]  present,
  output logic [NSLOT-1:0]  slot_pwr_en,
  output logic [NSLOT-1:0]  slot_rst_n,
  input  logic              ev_rd,
  output logic              ev_valid,
  output logic [SLOT_W-1:0] ev_slot,
  output logic [2:0]        ev_code,
  output logic [TS_W-1:0]   ev_ts,
  output logic              ev_ovf
);
  localparam int AW = $clog2(EV_DEPTH);
  localparam int NC = 3 * NSLOT;
  localparam int EW = SLOT_W + 3 + TS_W;
  localparam int PW = $clog2(NC + EV_DEPTH + 1) + 1;
  localparam logic [2:0] C_INS = 3'd0, C_REM = 3'd1, C_PGR = 3'd2,
                         C_PGF = 3'd3, C_REL = 3'd4, C_AST = 3'd5;

  logic [NSLOT-1:0] pres_q, pg_q, fault_q, rel_q;
  logic [NSLOT-1:0] flip, live, ready, grant, rst_drop;
  logic [DEB_W-1:0] dcnt [NSLOT];
  logic [DLY_W-1:0] wcnt [NSLOT];
  logic [TS_W-1:0]  ts_q;
  logic [DEB_W-1:0] deb_lim;

  assign deb_lim     = (deb_len == '0) ? DEB_W'(1) : deb_len;
  assign present     = pres_q;
  assign slot_pwr_en = pres_q & sw_en & ~fault_q;
  assign live        = slot_pwr_en & pgood;
  assign slot_rst_n  = rel_q & live;
  assign rst_drop    = rel_q & ~live;
  assign grant       = ready & (~ready + NSLOT'(1));

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      flip[i]  = tick && (prs_raw[i] != pres_q[i]) &&
                 (({1'b0, dcnt[i]} + {{DEB_W{1'b0}}, 1'b1}) >= {1'b0, deb_lim});
      ready[i] = !rel_q[i] && live[i] && (wcnt[i] >= rel_dly);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= '0;
      pg_q    <= '0;
      fault_q <= '0;
      rel_q   <= '0;
      ts_q    <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        dcnt[i] <= '0;
        wcnt[i] <= '0;
      end
    end else begin
      pres_q  <= pres_q ^ flip;
      pg_q    <= pgood;
      fault_q <= (fault_q | (pg_q & ~pgood & slot_pwr_en)) & sw_en;
      rel_q   <= (rel_q & live) | grant;
      if (tick) ts_q <= ts_q + TS_W'(1);
      for (int i = 0; i < NSLOT; i++) begin
        if (tick)
          dcnt[i] <= (flip[i] || prs_raw[i] == pres_q[i]) ? '0 : dcnt[i] + DEB_W'(1);
        if (!live[i])
          wcnt[i] <= '0;
        else if (tick && wcnt[i] < rel_dly)
          wcnt[i] <= wcnt[i] + DLY_W'(1);
      end
    end
  end

  logic [NC-1:0] cv, cacc;
  logic [EW-1:0] cd [NC];
  logic [PW-1:0] cpos [NC];
  logic [PW-1:0] n_acc;
  logic [AW:0]   fill;
  logic [AW-1:0] wptr, rptr;
  logic          pop, ovf_q;
  logic [EW-1:0] mem [EV_DEPTH];

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      cv[3*i]   = flip[i];
      cd[3*i]   = {SLOT_W'(i), (prs_raw[i] ? C_INS : C_REM), ts_q};
      cv[3*i+1] = pg_q[i] ^ pgood[i];
      cd[3*i+1] = {SLOT_W'(i), (pgood[i] ? C_PGR : C_PGF), ts_q};
      cv[3*i+2] = grant[i] | rst_drop[i];
      cd[3*i+2] = {SLOT_W'(i), (grant[i] ? C_REL : C_AST), ts_q};
    end
    n_acc = '0;
    for (int j = 0; j < NC; j++) begin
      cpos[j] = n_acc;
      cacc[j] = cv[j] && ((PW'(fill) + n_acc) < PW'(EV_DEPTH));
      if (cacc[j]) n_acc = n_acc + PW'(1);
    end
  end

  assign pop      = ev_rd && (fill != '0);
  assign ev_valid = (fill != '0);
  assign ev_ovf   = ovf_q;
  assign {ev_slot, ev_code, ev_ts} = mem[rptr];

  always_ff @(posedge clk) begin
    for (int j = 0; j < NC; j++)
      if (cacc[j]) mem[wptr + cpos[j][AW-1:0]] <= cd[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      fill  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wptr  <= wptr + n_acc[AW-1:0];
      rptr  <= rptr + AW'(pop);
      fill  <= fill + n_acc[AW:0] - (AW+1)'(pop);
      ovf_q <= ovf_q | (|(cv & ~cacc));
    end
  end

  assert_present_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_q != $past(pres_q)) |-> $past(tick));

  assert_one_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_q & ~$past(rel_q)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_ovf) |-> ev_ovf);

  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(EV_DEPTH));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    assert_release_after_pgood_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_rst_n[g]) |-> $past(pgood[g] && slot_pwr_en[g]));

    assert_fault_cuts_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(slot_pwr_en[g] && pg_q[g] && !pgood[g]) |-> !slot_pwr_en[g]);

    assert_removal_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pres_q[g]) |-> !slot_rst_n[g]);
  end
endmodule

// File: tb/hp_slot_seq_tb.sv
module hp_slot_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int DEPTH = 8;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ev_rd = 1'b0;
  logic [NS-1:0] prs_raw = '0, pgood = '0, sw_en = '0;
  logic [7:0] deb_len = 8'd3, rel_dly = 8'd4;
  logic [NS-1:0] present, slot_pwr_en, slot_rst_n;
  logic ev_valid, ev_ovf;
  logic [1:0] ev_slot;
  logic [2:0] ev_code;
  logic [15:0] ev_ts;

  hp_slot_seq #(.NSLOT(NS), .DEB_W(8), .DLY_W(8), .TS_W(16), .EV_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .prs_raw(prs_raw), .pgood(pgood),
    .sw_en(sw_en), .deb_len(deb_len), .rel_dly(rel_dly), .present(present),
    .slot_pwr_en(slot_pwr_en), .slot_rst_n(slot_rst_n), .ev_rd(ev_rd),
    .ev_valid(ev_valid), .ev_slot(ev_slot), .ev_code(ev_code), .ev_ts(ev_ts),
    .ev_ovf(ev_ovf));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // bench-side reference model
  logic [NS-1:0] m_pres, m_pgq, m_fault, m_rel;
  int m_dc [NS];
  int m_wc [NS];
  int m_ts;
  bit m_ovf;
  int q_slot[$];
  int q_code[$];
  int q_ts[$];
  int sent, room, t_lim, t_first;
  bit t_pop;
  logic [NS-1:0] t_pw, t_lv, t_np;

  function automatic logic [NS-1:0] m_power();
    return m_pres & sw_en & ~m_fault;
  endfunction

  task automatic m_push(int s, int c);
    if (sent < room) begin
      q_slot.push_back(s);
      q_code.push_back(c);
      q_ts.push_back(m_ts);
      sent++;
    end else m_ovf = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pres = '0; m_pgq = '0; m_fault = '0; m_rel = '0; m_ts = 0; m_ovf = 1'b0;
      for (int i = 0; i < NS; i++) begin m_dc[i] = 0; m_wc[i] = 0; end
      q_slot.delete(); q_code.delete(); q_ts.delete();
    end else begin
      t_pw = m_power();
      t_lv = t_pw & pgood;
      t_lim = (deb_len == 0) ? 1 : int'(deb_len);
      t_pop = ev_rd && (q_slot.size() > 0);
      t_np = m_pres;
      t_first = -1;
      for (int i = 0; i < NS; i++)
        if (t_first < 0 && !m_rel[i] && t_lv[i] && m_wc[i] >= int'(rel_dly)) t_first = i;
      room = DEPTH - q_slot.size();
      sent = 0;
      for (int i = 0; i < NS; i++) begin
        if (tick) begin
          if (prs_raw[i] == m_pres[i]) m_dc[i] = 0;
          else if (m_dc[i] + 1 >= t_lim) begin
            m_push(i, prs_raw[i] ? 0 : 1);
            t_np[i] = prs_raw[i];
            m_dc[i] = 0;
          end else m_dc[i]++;
        end
        if (pgood[i] && !m_pgq[i]) m_push(i, 2);
        else if (!pgood[i] && m_pgq[i]) m_push(i, 3);
        if (i == t_first) m_push(i, 4);
        else if (m_rel[i] && !t_lv[i]) m_push(i, 5);
        if (!t_lv[i]) m_wc[i] = 0;
        else if (tick && m_wc[i] < int'(rel_dly)) m_wc[i]++;
      end
      m_fault = (m_fault | (m_pgq & ~pgood & t_pw)) & sw_en;
      m_rel = m_rel & t_lv;
      if (t_first >= 0) m_rel[t_first] = 1'b1;
      m_pgq = pgood;
      m_pres = t_np;
      if (tick) m_ts = (m_ts + 1) & 32'hffff;
      if (t_pop) begin
        void'(q_slot.pop_front());
        void'(q_code.pop_front());
        void'(q_ts.pop_front());
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic compare();
    logic [NS-1:0] epw, erst;
    int act, exp;
    epw = m_power();
    erst = m_rel & epw & pgood;
    chk(present == m_pres, "R1", "present", int'(present), int'(m_pres));
    chk(slot_pwr_en == epw, "R2 R3", "pwr_en", int'(slot_pwr_en), int'(epw));
    chk(slot_rst_n == erst, "R4 R6", "rst_n", int'(slot_rst_n), int'(erst));
    chk(ev_valid == (q_slot.size() > 0), "R10", "ev_valid", int'(ev_valid), q_slot.size());
    if (ev_valid && q_slot.size() > 0) begin
      act = int'(ev_slot) * 524288 + int'(ev_code) * 65536 + int'(ev_ts);
      exp = q_slot[0] * 524288 + q_code[0] * 65536 + q_ts[0];
      chk(act == exp, "R7 R8", "head", act, exp);
    end
    chk(ev_ovf == m_ovf, "R9", "ev_ovf", int'(ev_ovf), int'(m_ovf));
  endtask

  int tdiv = 0;
  bit rnd_tick = 1'b0;

  task automatic step();
    @(negedge clk);
    if (rnd_tick) tick = ($urandom % 3 == 0);
    else begin
      tick = (tdiv == 2);
      tdiv = (tdiv + 1) % 3;
    end
    #1 compare();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "R10", "watchdog", cyc, WD_LIMIT);
      finish_up();
    end
  end

  initial begin
    int seed, nexp;
    logic [NS-1:0] prev, nb;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(present == 0 && slot_pwr_en == 0 && slot_rst_n == 0, "R11", "outs", int'(slot_rst_n), 0);
    chk(!ev_valid && !ev_ovf, "R11", "queue", int'(ev_valid), 0);
    rst_n = 1'b1;

    // R1 bounce shorter than the filter
    sw_en = '1; deb_len = 8'd4; rel_dly = 8'd4; ev_rd = 1'b0;
    prs_raw[0] = 1'b1;
    repeat (9) step();
    prs_raw[0] = 1'b0;
    repeat (6) step();
    chk(present[0] == 1'b0, "R1", "bounce_ignored", int'(present[0]), 0);
    prs_raw[0] = 1'b1;
    repeat (15) step();
    chk(present[0] == 1'b1, "R1", "insert_taken", int'(present[0]), 1);

    // R5 all slots ready together
    prs_raw = '1;
    repeat (15) step();
    chk(present == '1, "R1", "all_present", int'(present), 15);
    pgood = '1;
    prev = slot_rst_n;
    nexp = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (slot_rst_n != prev) begin
        nb = slot_rst_n & ~prev;
        chk(nb == NS'(1 << nexp), "R5", "release_order", int'(nb), 1 << nexp);
        nexp++;
        prev = slot_rst_n;
      end
    end
    chk(nexp == NS, "R5", "release_count", nexp, NS);

    // R9 queue filled without reads
    chk(ev_ovf == 1'b1, "R9", "ovf_set", int'(ev_ovf), 1);
    chk(ev_slot == 0 && ev_code == 0, "R9", "oldest_kept", int'(ev_code), 0);

    // R6 / R3 power-good loss on slot 2
    pgood[2] = 1'b0;
    #1;
    chk(slot_rst_n[2] == 1'b0, "R6", "same_cycle_reset", int'(slot_rst_n[2]), 0);
    chk(slot_rst_n[0] == 1'b1, "R6", "others_kept", int'(slot_rst_n[0]), 1);
    step();
    chk(slot_pwr_en[2] == 1'b0, "R3", "fault_power_off", int'(slot_pwr_en[2]), 0);
    chk(slot_pwr_en[3] == 1'b1, "R3", "neighbour_on", int'(slot_pwr_en[3]), 1);
    pgood[2] = 1'b1;
    repeat (3) step();
    chk(slot_pwr_en[2] == 1'b0, "R3", "fault_held", int'(slot_pwr_en[2]), 0);
    sw_en[2] = 1'b0;
    step();
    sw_en[2] = 1'b1;
    step();
    chk(slot_pwr_en[2] == 1'b1, "R3", "fault_cleared", int'(slot_pwr_en[2]), 1);

    // R10 drain
    ev_rd = 1'b1;
    repeat (40) step();
    chk(ev_valid == 1'b0, "R10", "drained", int'(ev_valid), 0);
    chk(ev_ovf == 1'b1, "R9", "ovf_sticky", int'(ev_ovf), 1);

    // R1 zero filter length acts as one
    deb_len = 8'd0;
    prs_raw[3] = 1'b0;
    repeat (4) step();
    chk(present[3] == 1'b0, "R1", "len_zero", int'(present[3]), 0);

    // random phase
    rnd_tick = 1'b1;
    deb_len = 8'd2;
    rel_dly = 8'd3;
    for (int k = 0; k < 6000; k++) begin
      step();
      for (int i = 0; i < NS; i++) begin
        int r;
        if ($urandom % 20 == 0) prs_raw[i] = ~prs_raw[i];
        r = $urandom % 32;
        if (r == 0) pgood[i] = ~pgood[i];
        else if (r < 6) pgood[i] = slot_pwr_en[i];
        if ($urandom % 200 == 0) sw_en[i] = ~sw_en[i];
      end
      ev_rd = ($urandom % 2 == 0);
      if ($urandom % 500 == 0) deb_len = 8'($urandom % 4);
      if ($urandom % 500 == 0) rel_dly = 8'($urandom % 6);
    end
    finish_up();
  end
endmodule